// File: doc/BRIEF.md
# Switchable-Depth UART Receive Buffer

This block holds received characters for a UART until software reads them. Each entry is 12 bits wide: an 8-bit character in the low bits and 4 status bits (framing, parity, break, overrun) above it. The buffer carries those bits unchanged. A mode input selects how it is organised. When the input is high, the buffer is a 16-entry circular queue. When it is low, the buffer is a single holding register. The buffer is flushed every time that input changes level.

Writes come from the receiver or the loopback path as one-cycle enable pulses that carry data. Reads are one-cycle pulses produced by a read of the data register. The head entry is always visible on the output. Empty, full and ready-to-accept flags are registered. A set pulse and a clear pulse drive a receive-interrupt latch that lives elsewhere. They are placed around a trigger count, which is fixed at 1 by default.

Top module: `uart_rx_buffer`

## Requirements
- R1: After a synchronous reset the buffer is empty. `empty`=1, `full`=0, `can_accept`=1, and `rxint_set` and `rxint_clr` are both 0. The buffer starts in holding-register mode.
- R2: Entries are read out in the order they were written. `rd_data` always shows the oldest stored entry, meaning the entry at the read position.
- R3: In queue mode (`fifo_en`=1) the buffer holds 16 entries. The 16th write raises `full` and lowers `can_accept`. Any write while full is discarded and changes neither the stored entries nor the head.
- R4: In holding mode (`fifo_en`=0) the depth is 1. A single write makes the buffer full, and later writes are discarded until a read is made.
- R5: A read while empty changes no pointer and no flag. `rd_data` keeps showing the entry at the unchanged read position.
- R6: When a read and a write are accepted in the same cycle, the count stays the same. When the buffer is full and both arrive together, the read is taken and the write is discarded.
- R7: `rxint_set` pulses high for one cycle after a write brings the count to the trigger level (1).
- R8: `rxint_clr` pulses high for one cycle after any read that leaves the count one below the trigger level. This includes a read of an empty buffer.
- R9: A change of `fifo_en` flushes the buffer in that cycle. The count and read position return to 0, `empty`=1 and `full`=0, and any write or read in that cycle is ignored.
- R10: Positions wrap modulo the current depth. After the write position passes the last slot, new entries go to slot 0 and keep their order behind older entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1 = 16-entry queue, 0 = single holding register; any change flushes |
| wr_en | input | 1 | Write pulse from receiver or loopback |
| wr_data | input | 12 | Entry to store: status [11:8], character [7:0] |
| rd_en | input | 1 | Read pulse from a data-register read |
| rd_data | output | 12 | Entry at the read position |
| empty | output | 1 | Count is zero |
| full | output | 1 | Count equals the current depth |
| can_accept | output | 1 | Count is below the current depth |
| rxint_set | output | 1 | One-cycle pulse: receive interrupt set |
| rxint_clr | output | 1 | One-cycle pulse: receive interrupt clear |

## Verification
All flags and interrupt pulses are registered. Each one reflects the stimulus applied before a rising edge and is valid from just after that edge. `rd_data` follows the registered read position, so it is valid in the same cycle. A flush also completes in one cycle. The bench changes inputs on the falling edge and samples all outputs on the next falling edge. Each stimulus is therefore checked exactly one rising edge after it was applied, with no dependence on process order.

// File: rtl/uart_rxbuf_pkg.sv
package uart_rxbuf_pkg;
  localparam int CHAR_W  = 8;
  localparam int STAT_W  = 4;
  localparam int ENTRY_W = CHAR_W + STAT_W;
  typedef logic [ENTRY_W-1:0] rx_entry_t;
endpackage

// File: rtl/rxbuf_mode.sv
module rxbuf_mode #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_en,
  output logic             flush,
  output logic [CNT_W-1:0] depth_cur,
  output logic [PTR_W-1:0] mask_cur
);
  logic mode_q;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= 1'b0;
    else     mode_q <= fifo_en;
  end

  assign flush     = (fifo_en != mode_q) && !rst;
  assign depth_cur = mode_q ? CNT_W'(DEPTH) : CNT_W'(1);
  assign mask_cur  = mode_q ? PTR_W'(DEPTH - 1) : '0;
endmodule

// File: rtl/rxbuf_store.sv
module rxbuf_store
  import uart_rxbuf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  rx_entry_t        wdata,
  input  logic [PTR_W-1:0] raddr,
  output rx_entry_t        rdata
);
  rx_entry_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rxbuf_ctrl.sv
module rxbuf_ctrl #(
  parameter int DEPTH   = 16,
  parameter int TRIGGER = 1,
  parameter int CNT_W   = $clog2(DEPTH + 1),
  parameter int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [CNT_W-1:0] depth_cur,
  input  logic [PTR_W-1:0] mask_cur,
  input  logic             wr_en,
  input  logic             rd_en,
  output logic             wr_ok,
  output logic [PTR_W-1:0] wslot,
  output logic [PTR_W-1:0] rpos,
  output logic             empty,
  output logic             full,
  output logic             can_accept,
  output logic             rxint_set,
  output logic             rxint_clr
);
  localparam logic [CNT_W-1:0] TRIG    = CNT_W'(TRIGGER);
  localparam logic [CNT_W-1:0] TRIG_M1 = CNT_W'(TRIGGER - 1);

  logic [CNT_W-1:0] count_q, cnt_nxt;
  logic [PTR_W-1:0] rpos_q, rpos_nxt;
  logic             rd_ok;
  logic             empty_q, full_q, acc_q, set_q, clr_q;

  always_comb begin
    wr_ok = wr_en && !flush && (count_q < depth_cur);
    rd_ok = rd_en && !flush && (count_q != '0);
    wslot = (rpos_q + count_q[PTR_W-1:0]) & mask_cur;
    case ({wr_ok, rd_ok})
      2'b10:   cnt_nxt = count_q + CNT_W'(1);
      2'b01:   cnt_nxt = count_q - CNT_W'(1);
      default: cnt_nxt = count_q;
    endcase
    rpos_nxt = rd_ok ? ((rpos_q + PTR_W'(1)) & mask_cur) : rpos_q;
    if (flush) begin
      cnt_nxt  = '0;
      rpos_nxt = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      rpos_q  <= '0;
      empty_q <= 1'b1;
      full_q  <= 1'b0;
      acc_q   <= 1'b1;
      set_q   <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      count_q <= cnt_nxt;
      rpos_q  <= rpos_nxt;
      empty_q <= (cnt_nxt == '0);
      full_q  <= !flush && (cnt_nxt == depth_cur);
      acc_q   <= flush || (cnt_nxt < depth_cur);
      set_q   <= wr_ok && (cnt_nxt == TRIG);
      clr_q   <= rd_en && !flush && (cnt_nxt == TRIG_M1);
    end
  end

  assign rpos       = rpos_q;
  assign empty      = empty_q;
  assign full       = full_q;
  assign can_accept = acc_q;
  assign rxint_set  = set_q;
  assign rxint_clr  = clr_q;

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count_q <= depth_cur); // R3
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    full_q |-> !acc_q); // R4
  AST_EMPTY_READ_STILL: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && empty_q && !flush) |=> ($stable(rpos_q) && empty_q)); // R5
  AST_NET_ZERO: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_en && !flush && !empty_q && !full_q) |=> $stable(count_q)); // R6
  AST_SET_CLR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(set_q && clr_q)); // R7
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> (empty_q && !full_q && count_q == '0 && rpos_q == '0)); // R9
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
  import uart_rxbuf_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int TRIGGER = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fifo_en,
  input  logic               wr_en,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic               rd_en,
  output logic [ENTRY_W-1:0] rd_data,
  output logic               empty,
  output logic               full,
  output logic               can_accept,
  output logic               rxint_set,
  output logic               rxint_clr
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic             flush, wr_ok;
  logic [CNT_W-1:0] depth_cur;
  logic [PTR_W-1:0] mask_cur, wslot, rpos;

  rxbuf_mode #(.DEPTH(DEPTH), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_mode (
    .clk(clk), .rst(rst), .fifo_en(fifo_en),
    .flush(flush), .depth_cur(depth_cur), .mask_cur(mask_cur)
  );

  rxbuf_ctrl #(.DEPTH(DEPTH), .TRIGGER(TRIGGER), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_ctrl (
    .clk(clk), .rst(rst), .flush(flush), .depth_cur(depth_cur), .mask_cur(mask_cur),
    .wr_en(wr_en), .rd_en(rd_en), .wr_ok(wr_ok), .wslot(wslot), .rpos(rpos),
    .empty(empty), .full(full), .can_accept(can_accept),
    .rxint_set(rxint_set), .rxint_clr(rxint_clr)
  );

  rxbuf_store #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
    .clk(clk), .we(wr_ok), .waddr(wslot), .wdata(wr_data),
    .raddr(rpos), .rdata(rd_data)
  );
endmodule

// File: tb/uart_rx_buffer_test.sv
module uart_rx_buffer_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fifo_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] wr_data = '0;
  logic [11:0] rd_data;
  logic empty, full, can_accept, rxint_set, rxint_clr;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  uart_rx_buffer uut (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .empty(empty), .full(full),
    .can_accept(can_accept), .rxint_set(rxint_set), .rxint_clr(rxint_clr)
  );

  typedef struct packed {
    logic en, wr, rd;
    logic [11:0] d;
    logic e, f, a, s, c;
    logic cd;
    logic [11:0] q;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b1,1'b0,12'h0A1, 1'b0,1'b1,1'b0,1'b1,1'b0, 1'b1,12'h0A1}, // R4 R7 one write fills
    '{1'b0,1'b1,1'b0,12'h0B2, 1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1,12'h0A1}, // R4 dropped
    '{1'b0,1'b0,1'b1,12'h000, 1'b1,1'b0,1'b1,1'b0,1'b1, 1'b1,12'h0A1}, // R8 read empties
    '{1'b0,1'b0,1'b1,12'h000, 1'b1,1'b0,1'b1,1'b0,1'b1, 1'b1,12'h0A1}, // R5 R8 empty read
    '{1'b0,1'b1,1'b1,12'h0C3, 1'b0,1'b1,1'b0,1'b1,1'b0, 1'b1,12'h0C3}, // R6 both on empty
    '{1'b0,1'b1,1'b1,12'h0D4, 1'b1,1'b0,1'b1,1'b0,1'b1, 1'b1,12'h0C3}, // R6 both on full
    '{1'b1,1'b1,1'b0,12'h111, 1'b1,1'b0,1'b1,1'b0,1'b0, 1'b0,12'h000}, // R9 flush ignores write
    '{1'b1,1'b1,1'b0,12'h122, 1'b0,1'b0,1'b1,1'b1,1'b0, 1'b1,12'h122}, // R7
    '{1'b1,1'b1,1'b0,12'h133, 1'b0,1'b0,1'b1,1'b0,1'b0, 1'b1,12'h122}, // R2
    '{1'b1,1'b1,1'b1,12'h144, 1'b0,1'b0,1'b1,1'b0,1'b0, 1'b1,12'h133}, // R6 net zero
    '{1'b1,1'b0,1'b1,12'h000, 1'b0,1'b0,1'b1,1'b0,1'b0, 1'b1,12'h144}, // R2
    '{1'b1,1'b0,1'b1,12'h000, 1'b1,1'b0,1'b1,1'b0,1'b1, 1'b0,12'h000}, // R8
    '{1'b0,1'b0,1'b0,12'h000, 1'b1,1'b0,1'b1,1'b0,1'b0, 1'b0,12'h000}  // R9 flush back
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic wr, input logic rd, input logic [11:0] d);
    fifo_en = en; wr_en = wr; rd_en = rd; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    #4_000_000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 empty", empty, 1); chk("R1 full", full, 0);
    chk("R1 can_accept", can_accept, 1);
    chk("R1 set", rxint_set, 0); chk("R1 clr", rxint_clr, 0);

    for (int i = 0; i < NV; i++) begin
      step(TBL[i].en, TBL[i].wr, TBL[i].rd, TBL[i].d);
      chk($sformatf("R4 empty row%0d", i), empty, TBL[i].e);
      chk($sformatf("R4 full row%0d", i), full, TBL[i].f);
      chk($sformatf("R4 accept row%0d", i), can_accept, TBL[i].a);
      chk($sformatf("R7 set row%0d", i), rxint_set, TBL[i].s);
      chk($sformatf("R8 clr row%0d", i), rxint_clr, TBL[i].c);
      if (TBL[i].cd) chk($sformatf("R2 data row%0d", i), rd_data, TBL[i].q);
    end

    // R3 fill queue mode to 16
    step(1'b1, 1'b0, 1'b0, 12'h0); // R9 flush into queue mode
    chk("R9 empty after enable", empty, 1);
    for (int i = 0; i < 16; i++) begin
      step(1'b1, 1'b1, 1'b0, 12'h200 + 12'(i));
      chk($sformatf("R3 full after %0d", i + 1), full, (i == 15));
      chk($sformatf("R3 accept after %0d", i + 1), can_accept, (i != 15));
    end
    step(1'b1, 1'b1, 1'b0, 12'h2FF);
    chk("R3 head after overflow", rd_data, 12'h200);
    chk("R3 still full", full, 1);

    // R2 read 8 in order
    for (int i = 0; i < 8; i++) begin
      chk($sformatf("R2 order %0d", i), rd_data, 12'h200 + 12'(i));
      step(1'b1, 1'b0, 1'b1, 12'h0);
    end
    chk("R2 not full after reads", full, 0);

    // R10 write 8 more, which wrap into slots 0..7
    for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 1'b0, 12'h300 + 12'(i));
    chk("R10 full after wrap fill", full, 1);
    for (int i = 0; i < 16; i++) begin
      chk($sformatf("R10 wrap order %0d", i), rd_data,
          (i < 8) ? 12'h208 + 12'(i) : 12'h300 + 12'(i - 8));
      step(1'b1, 1'b0, 1'b1, 12'h0);
    end
    chk("R10 empty after drain", empty, 1);

    // R9 flush with data present
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, 12'h400 + 12'(i));
    chk("R9 not empty before flush", empty, 0);
    step(1'b0, 1'b0, 1'b0, 12'h0);
    chk("R9 empty after flush", empty, 1);
    chk("R9 full after flush", full, 0);
    step(1'b1, 1'b0, 1'b0, 12'h0);
    step(1'b1, 1'b1, 1'b0, 12'h055);
    chk("R9 head after reflush", rd_data, 12'h055);
    step(1'b1, 1'b0, 1'b1, 12'h0);
    chk("R9 single entry left", empty, 1);
    chk("R8 clr after last read", rxint_clr, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule